// File: doc/BRIEF.md
# Gated Pulse-Count Wiper Calibrator

This block positions the wiper of a digitally programmable potentiometer that has only an increment/decrement control. The analog quantity to be captured has already been converted into a pulse train whose rate is proportional to it. A calibration request opens a gate of fixed length. Every input pulse that arrives while the gate is open becomes one increment strobe, so the final wiper tap is the number of pulses counted in the window.

A calibration can be requested in two ways. One is a raw mechanical switch, which is synchronised, debounced, and acted on only on its press edge. The other is a logic trigger from a host, which is synchronised and edge-detected. Either source fires a short trigger pulse, and that pulse starts a one-shot gate. The gate length is (TAPS-1) full-scale pulse periods, so a full-scale input lands exactly on the top tap. While the gate is open the block asserts the potentiometer select and keeps the direction line at "up". The block keeps its own count of the wiper position since reset and stops strobing once the top tap is reached.

Top module: `wcal_top`

## Requirements
- R1: Each rising edge of `freq_pulse_i` that is detected while the gate is open produces exactly one `pot_inc_o` strobe, one clock cycle wide.
- R2: No `pot_inc_o` strobe is produced while the gate is closed, whatever `freq_pulse_i` does.
- R3: The gate (`cal_gate_o` high) lasts exactly (TAPS-1)*FS_PERIOD_CYC clock cycles. A pulse stream at the full-scale period that starts with the gate therefore yields exactly TAPS-1 strobes (31 with defaults).
- R4: `pot_up_o` is always 1. `pot_sel_o` is 1 exactly when `cal_gate_o` is 1.
- R5: After reset, `pot_inc_o`, `cal_gate_o` and `pot_sel_o` are 0, and the internal wiper count is 0, so a later calibration counts up from tap 0.
- R6: A change of `cal_sw_i` that lasts fewer than DEB_CYC cycles is ignored. A press (0 to 1) held stable for DEB_CYC cycles starts one gate. A release (1 to 0) starts none.
- R7: A rising edge on `ext_trig_i` starts a gate.
- R8: A trigger from either source that arrives while the gate is open is ignored. The gate neither restarts nor lengthens, and no second gate follows.
- R9: Once TAPS-1 strobes have been issued since reset, further pulses inside a gate produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_sw_i | input | 1 | Raw calibrate switch level (1 = pressed), asynchronous |
| ext_trig_i | input | 1 | Host calibrate trigger, acts on its rising edge, asynchronous |
| freq_pulse_i | input | 1 | Pulse train from the voltage-to-frequency converter, asynchronous |
| pot_inc_o | output | 1 | One-cycle increment strobe to the potentiometer |
| pot_up_o | output | 1 | Direction to the potentiometer, fixed at 1 (up) |
| pot_sel_o | output | 1 | Potentiometer select, active high during the gate |
| cal_gate_o | output | 1 | Gate window is open |

## Verification
The hardest condition to reach is saturation at the top tap partway through a gate. The count must already be close to the top when a new window opens, and the window must then carry more pulses than there are taps left. The stimulus first runs two partial calibrations that leave the wiper at 17. It then opens a third gate with a full-scale stream, so only 14 of the roughly 31 pulses may become strobes. A retrigger is also sent while the second gate is open, so the gate-length measurement covers the non-retriggerable case.

// File: rtl/wcal_pkg.sv
package wcal_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_st_e;
endpackage

// File: rtl/wcal_sync_edge.sv
module wcal_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wcal_trigger.sv
module wcal_trigger #(
  parameter int DEB_CYC     = 8,
  parameter int TRIG_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_i,
  input  logic ext_i,
  output logic start_o
);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int TW = $clog2(TRIG_CYC + 1);

  logic          sw_lvl, sw_rise_unused, ext_lvl_unused, ext_rise;
  logic          stable_q, stable_n;
  logic [DW-1:0] dcnt_q, dcnt_n;
  logic [TW-1:0] tcnt_q, tcnt_n;
  logic          press, arm, start_n, start_q;

  wcal_sync_edge #(.STAGES(SYNC_STAGES)) u_sw_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sw_i), .level_o(sw_lvl), .rise_o(sw_rise_unused));
  wcal_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_i), .level_o(ext_lvl_unused), .rise_o(ext_rise));

  // debounce: accept a new level only after DEB_CYC consecutive differing samples
  always_comb begin
    stable_n = stable_q;
    dcnt_n   = '0;
    press    = 1'b0;
    if (sw_lvl != stable_q) begin
      if (dcnt_q == DW'(DEB_CYC - 1)) begin
        stable_n = sw_lvl;
        press    = sw_lvl;
      end else begin
        dcnt_n = dcnt_q + 1'b1;
      end
    end
  end

  // trigger pulse stretcher; start fires on its leading edge only
  always_comb begin
    arm     = press | ext_rise;
    start_n = 1'b0;
    tcnt_n  = tcnt_q;
    if (tcnt_q == '0) begin
      if (arm) begin
        tcnt_n  = TW'(TRIG_CYC);
        start_n = 1'b1;
      end
    end else begin
      tcnt_n = tcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      dcnt_q   <= '0;
      tcnt_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      stable_q <= stable_n;
      dcnt_q   <= dcnt_n;
      tcnt_q   <= tcnt_n;
      start_q  <= start_n;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/wcal_gate.sv
module wcal_gate
  import wcal_pkg::*;
#(
  parameter int GATE_CYC = 620
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic gate_o
);
  localparam int CW = $clog2(GATE_CYC + 1);

  gate_st_e      st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      GATE_IDLE: if (start_i) begin
        st_n  = GATE_OPEN;
        cnt_n = CW'(GATE_CYC - 1);
      end
      GATE_OPEN: begin
        if (cnt_q == '0) st_n = GATE_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      default: st_n = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GATE_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign gate_o = (st_q == GATE_OPEN);
endmodule

// File: rtl/wcal_top.sv
module wcal_top #(
  parameter int TAPS          = 32,
  parameter int FS_PERIOD_CYC = 20,
  parameter int DEB_CYC       = 8,
  parameter int TRIG_CYC      = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_sw_i,
  input  logic ext_trig_i,
  input  logic freq_pulse_i,
  output logic pot_inc_o,
  output logic pot_up_o,
  output logic pot_sel_o,
  output logic cal_gate_o
);
  localparam int GATE_CYC = (TAPS - 1) * FS_PERIOD_CYC;
  localparam int PW       = $clog2(TAPS);

  logic [1:0]    rst_sh_q;
  logic          rst_int_n;
  logic          start, gate;
  logic          pls_lvl_unused, pls_rise;
  logic [PW-1:0] pos_q, pos_n;
  logic          inc_q, inc_n;
  logic          at_top;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  wcal_trigger #(.DEB_CYC(DEB_CYC), .TRIG_CYC(TRIG_CYC), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_int_n), .sw_i(cal_sw_i), .ext_i(ext_trig_i), .start_o(start));

  wcal_gate #(.GATE_CYC(GATE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .start_i(start), .gate_o(gate));

  wcal_sync_edge #(.STAGES(SYNC_STAGES)) u_pls_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(freq_pulse_i), .level_o(pls_lvl_unused), .rise_o(pls_rise));

  always_comb begin
    at_top = (pos_q == PW'(TAPS - 1));
    inc_n  = pls_rise & gate & ~at_top;
    pos_n  = pos_q;
    if (inc_n) pos_n = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pos_q <= '0;
      inc_q <= 1'b0;
    end else begin
      pos_q <= pos_n;
      inc_q <= inc_n;
    end
  end

  assign pot_inc_o  = inc_q;
  assign pot_up_o   = 1'b1;
  assign pot_sel_o  = gate;
  assign cal_gate_o = gate;
endmodule

// File: rtl/wcal_checker.sv
module wcal_checker #(
  parameter int TAPS     = 32,
  parameter int GATE_CYC = 620
) (
  input logic clk,
  input logic rst_n,
  input logic inc,
  input logic up,
  input logic sel,
  input logic gate
);
  localparam int GW = $clog2(GATE_CYC + 2);
  localparam int IW = $clog2(TAPS) + 1;

  logic [GW-1:0] glen_q;
  logic [IW-1:0] icnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glen_q <= '0;
      icnt_q <= '0;
    end else begin
      if (gate) glen_q <= (glen_q == GW'(GATE_CYC + 1)) ? glen_q : glen_q + 1'b1;
      else      glen_q <= '0;
      if (inc && icnt_q != IW'(TAPS)) icnt_q <= icnt_q + 1'b1;
    end
  end

  AST_INC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> $past(gate)) else $error("strobe outside gate"); // R2
  AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> !inc) else $error("strobe wider than one cycle"); // R1
  AST_UP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    up) else $error("direction not up"); // R4
  AST_SEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sel == gate) else $error("select differs from gate"); // R4
  AST_GATE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> glen_q < GW'(GATE_CYC)) else $error("gate too long"); // R8
  AST_GATE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> glen_q == GW'(GATE_CYC)) else $error("gate length wrong"); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_q <= IW'(TAPS - 1)) else $error("strobes beyond top tap"); // R9
endmodule

bind wcal_top wcal_checker #(.TAPS(TAPS), .GATE_CYC(GATE_CYC)) u_wcal_chk (
  .clk(clk), .rst_n(rst_n), .inc(pot_inc_o), .up(pot_up_o), .sel(pot_sel_o), .gate(cal_gate_o));

// File: tb/wcal_top_bench.sv
module wcal_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS       = 32;
  localparam int FS_PER     = 20;
  localparam int DEB        = 8;
  localparam int GATE       = (TAPS - 1) * FS_PER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0, ext = 1'b0, pls = 1'b0;
  logic inc, up, sel, gate;

  int tests = 0, fails = 0;
  int exp_q[$];
  int model_wiper = 0;   // behavioural potentiometer
  int exp_pos = 0;       // bench reference of wiper
  int win_incs = 0;
  int glen = 0;
  int gate_count = 0;
  logic gate_prev = 1'b0;
  logic mon_busy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcal_top #(.TAPS(TAPS), .FS_PERIOD_CYC(FS_PER), .DEB_CYC(DEB), .TRIG_CYC(4)) u_wcal_top (
    .clk(clk), .rst_n(rst_n), .cal_sw_i(sw), .ext_trig_i(ext), .freq_pulse_i(pls),
    .pot_inc_o(inc), .pot_up_o(up), .pot_sel_o(sel), .cal_gate_o(gate));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: potentiometer model, gate width, scoreboard pop at gate close
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        model_wiper = 0; win_incs = 0; glen = 0; gate_prev = 1'b0;
      end else begin
        if (inc) begin
          win_incs++;
          if (model_wiper < TAPS - 1) model_wiper++;
        end
        check("R4 up", int'(up), 1);
        if (sel !== gate) check("R4 sel", int'(sel), int'(gate));
        if (gate) glen++;
        if (gate && !gate_prev) gate_count++;
        if (!gate && gate_prev) begin
          mon_busy = 1'b1;
          check("R3/R8 gate width", glen, GATE);
          glen = 0;
          repeat (5) begin
            @(negedge clk);
            if (inc) begin win_incs++; if (model_wiper < TAPS - 1) model_wiper++; end
          end
          if (exp_q.size() == 0) check("R1 unexpected window", 1, 0);
          else check("R1/R9 strobes in window", win_incs, exp_q.pop_front());
          win_incs = 0;
          mon_busy = 1'b0;
        end
        gate_prev = gate;
      end
    end
  end

  task automatic pulse(input int period);
    pls = 1'b1; repeat (2) @(negedge clk);
    pls = 1'b0; repeat (period - 2) @(negedge clk);
  endtask

  task automatic wait_gate_open();
    int n = 0;
    while (!gate && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic wait_gate_done();
    while (gate) @(negedge clk);
    @(negedge clk);
    while (mon_busy) @(negedge clk);
  endtask

  // driver: open a gate, push the expected strobe count, send n pulses
  task automatic run_cal(input bit use_sw, input int n, input int period, input bit retrig);
    int e;
    if (use_sw) sw = 1'b1; else ext = 1'b1;
    wait_gate_open();
    e = (n < TAPS - 1 - exp_pos) ? n : TAPS - 1 - exp_pos;
    exp_q.push_back(e);
    exp_pos += e;
    ext = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pulse(period);
      if (retrig && i == 2) begin ext = 1'b1; repeat (3) @(negedge clk); ext = 1'b0; end
    end
    wait_gate_done();
    if (use_sw) begin sw = 1'b0; repeat (20) @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 inc", int'(inc), 0);
    check("R5 gate", int'(gate), 0);
    check("R5 sel", int'(sel), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 pulses with gate closed
    for (int i = 0; i < 5; i++) pulse(10);
    repeat (5) @(negedge clk);
    check("R2 no strobe outside gate", model_wiper, 0);

    // R6 short bounces ignored
    g0 = gate_count;
    for (int i = 0; i < 4; i++) begin
      sw = 1'b1; repeat (3) @(negedge clk);
      sw = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    check("R6 bounce ignored", gate_count - g0, 0);

    // R6 stable press: 12 pulses, release must not start a gate
    g0 = gate_count;
    run_cal(1'b1, 12, FS_PER, 1'b0);
    repeat (40) @(negedge clk);
    check("R6 one gate per press", gate_count - g0, 1);
    check("R1 wiper after 12", model_wiper, 12);

    // R7 external trigger, R8 retrigger during gate
    g0 = gate_count;
    run_cal(1'b0, 5, 50, 1'b1);
    repeat (40) @(negedge clk);
    check("R8 no second gate", gate_count - g0, 1);
    check("R7 wiper after 17", model_wiper, 17);

    // R9 saturation mid-gate with full-scale stream
    run_cal(1'b0, 36, FS_PER, 1'b0);
    check("R9 wiper at top", model_wiper, TAPS - 1);

    // R5 reset clears count; R3 full scale reaches top exactly
    rst_n = 1'b0; exp_pos = 0;
    repeat (3) @(negedge clk);
    check("R5 gate after reset", int'(gate), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 wiper cleared", model_wiper, 0);
    run_cal(1'b0, 36, FS_PER, 1'b0);
    check("R3 full scale top tap", model_wiper, TAPS - 1);

    check("R1 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule